// File: doc/BRIEF.md
# Signed/Unsigned Min-Max Selector

This block takes two integer operands and returns either the smaller or the larger of them. A two-bit mode picks the flavour: minimum or maximum, under unsigned or two's-complement ordering. It suits an integer execution pipe that needs one shared select unit for all four min/max operations.

When the record enable is set, the block also reports how operand A ranks against operand B. It does this as a four-bit condition field with one-hot less-than, greater-than and equal bits. The ranking uses the same signedness as the selected mode. The condition describes the A-versus-B comparison, not the sign of the result.

The data path is combinational. A parameter selects a registered output stage. In that variant the result and condition are captured on the clock edge at which an input strobe is sampled high. They are held until the next strobe, and an output strobe marks each new value.

Top module: `minmax_sel`

## Requirements
- R1: Operands and result are `WIDTH` bits wide, 64 by default, and the result is always equal to one of the two operands.
- R2: Mode 2'd0 (unsigned minimum) returns the operand that is smaller when both are read as unsigned numbers.
- R3: Mode 2'd1 (unsigned maximum) returns the operand that is larger when both are read as unsigned numbers.
- R4: Mode 2'd2 (signed minimum) returns the operand that is smaller in two's complement; 1 against 0x8000_0000_0000_0000 gives 0x8000_0000_0000_0000.
- R5: Mode 2'd3 (signed maximum) returns the operand that is larger in two's complement; 0x8000_0000_0000_0000 against 1 gives 1.
- R6: With record enabled, the condition field is 4'b1000 when A < B, 4'b0100 when A > B and 4'b0010 when A == B. The comparison uses the signedness given by mode bit 1 (1 = signed). Bit 0 of the field is always 0.
- R7: Equal operands give a result equal to A and the equal condition 4'b0010.
- R8: With record disabled, the condition field is 4'b0000 and the condition valid flag is low. With record enabled, the flag is high.
- R9: In the registered variant, the result, condition and flag change only on an edge where `in_valid` is sampled high, and they are visible after that edge. `out_valid` is high for exactly the cycle after each such edge.
- R10: A synchronous active-high reset clears the result, the condition, the condition valid flag and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; operands are captured on an edge where it is high |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| mode | input | 2 | Bit 1: signed ordering; bit 0: maximum (1) or minimum (0) |
| rec_en | input | 1 | Record enable for the condition field |
| result | output | WIDTH | Selected operand |
| cond | output | 4 | {lt, gt, eq, 0} when recording, else zero |
| cond_valid | output | 1 | High when the condition field holds a recorded value |
| out_valid | output | 1 | High in the cycle after an accepted input |

## Verification
The stimulus includes operand pairs whose most significant bits differ. For these pairs the unsigned and signed orderings disagree, so a wrong signedness in either the select or the condition shows up at once. Equal pairs, including the most negative value against itself, separate the equal case from strict ordering and check that A wins a tie. Random pairs across all four modes, with record toggled, check that the min and max polarity is right and that the condition field clears when record is off. Idle cycles with changed operands check that the registered outputs hold between strobes.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
   localparam int MODE_W = 2;
   localparam int COND_W = 4;
   localparam logic [COND_W-1:0] COND_LT = 4'b1000;
   localparam logic [COND_W-1:0] COND_GT = 4'b0100;
   localparam logic [COND_W-1:0] COND_EQ = 4'b0010;

   typedef enum logic [MODE_W-1:0] {
      MM_UMIN = 2'd0,
      MM_UMAX = 2'd1,
      MM_SMIN = 2'd2,
      MM_SMAX = 2'd3
   } mm_mode_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
   } mm_rank_t;
endpackage

// File: rtl/mm_rank.sv
module mm_rank
   import minmax_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_signed,
   output mm_rank_t         rank
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] a_key;
   logic [WIDTH-1:0] b_key;

   // Flipping the sign bit maps two's-complement order onto unsigned order.
   always_comb begin
      a_key = a;
      b_key = b;
      if (is_signed) begin
         a_key[MSB] = ~a[MSB];
         b_key[MSB] = ~b[MSB];
      end
   end

   always_comb begin
      rank.eq = (a == b);
      rank.lt = (a_key < b_key);
      rank.gt = ~rank.eq & ~rank.lt;
   end

   always_comb begin
      a_rank_onehot_r6 : assert ($onehot({rank.lt, rank.gt, rank.eq}) || $isunknown({a, b, is_signed}))
         else $error("rank flags not one-hot");
   end
endmodule

// File: rtl/mm_pick.sv
module mm_pick
   import minmax_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             want_max,
   input  mm_rank_t         rank,
   output logic [WIDTH-1:0] y
);
   logic take_b;

   // On a tie neither strict flag is set, so operand A is returned.
   always_comb begin
      take_b = want_max ? rank.lt : rank.gt;
      y      = take_b ? b : a;
   end

   always_comb begin
      a_pick_operand_r1 : assert (y == a || y == b || $isunknown({a, b, want_max}))
         else $error("result is neither operand");
   end
endmodule

// File: rtl/mm_flags.sv
module mm_flags
   import minmax_pkg::*;
(
   input  logic              rec_en,
   input  mm_rank_t          rank,
   output logic [COND_W-1:0] cond,
   output logic              cond_valid
);
   always_comb begin
      cond_valid = rec_en;
      cond       = '0;
      if (rec_en) begin
         cond = {rank.lt, rank.gt, rank.eq, 1'b0};
      end
   end
endmodule

// File: rtl/minmax_sel.sv
module minmax_sel
   import minmax_pkg::*;
#(
   parameter int WIDTH      = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [WIDTH-1:0]      op_a,
   input  logic [WIDTH-1:0]      op_b,
   input  logic [MODE_W-1:0]     mode,
   input  logic                  rec_en,
   output logic [WIDTH-1:0]      result,
   output logic [COND_W-1:0]     cond,
   output logic                  cond_valid,
   output logic                  out_valid
);
   initial begin
      a_width_ok : assert (WIDTH >= 2) else $error("WIDTH must be at least 2");
   end

   mm_rank_t          rank;
   logic [WIDTH-1:0]  y_comb;
   logic [COND_W-1:0] cond_comb;
   logic              cv_comb;

   mm_rank #(.WIDTH(WIDTH)) u_rank (
      .a         (op_a),
      .b         (op_b),
      .is_signed (mode[1]),
      .rank      (rank)
   );

   mm_pick #(.WIDTH(WIDTH)) u_pick (
      .a        (op_a),
      .b        (op_b),
      .want_max (mode[0]),
      .rank     (rank),
      .y        (y_comb)
   );

   mm_flags u_flags (
      .rec_en     (rec_en),
      .rank       (rank),
      .cond       (cond_comb),
      .cond_valid (cv_comb)
   );

   generate
      if (REGISTERED) begin : g_reg
         logic [WIDTH-1:0]  res_q;
         logic [COND_W-1:0] cond_q;
         logic              cv_q;
         logic              ov_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               res_q  <= '0;
               cond_q <= '0;
               cv_q   <= 1'b0;
               ov_q   <= 1'b0;
            end else begin
               ov_q <= in_valid;
               if (in_valid) begin
                  res_q  <= y_comb;
                  cond_q <= cond_comb;
                  cv_q   <= cv_comb;
               end
            end
         end

         assign result     = res_q;
         assign cond       = cond_q;
         assign cond_valid = cv_q;
         assign out_valid  = ov_q;

         p_cond_shape_r6 : assert property (@(posedge clk) disable iff (rst)
            cv_q |-> ($countones(cond_q) == 1 && !cond_q[0]));
         p_norec_zero_r8 : assert property (@(posedge clk) disable iff (rst)
            !cv_q |-> (cond_q == '0));
         p_hold_r9 : assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(res_q) && $stable(cond_q) && $stable(cv_q)));
         p_ovalid_up_r9 : assert property (@(posedge clk) disable iff (rst)
            in_valid |=> ov_q);
         p_ovalid_dn_r9 : assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !ov_q);
         p_max_takes_b_r5 : assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode[0] && rec_en) |=> ((cond_q != COND_LT) || (res_q == $past(op_b))));
         p_tie_takes_a_r7 : assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_a == op_b) |=> (res_q == $past(op_a)));
      end else begin : g_comb
         assign result     = y_comb;
         assign cond       = cond_comb;
         assign cond_valid = cv_comb;
         assign out_valid  = in_valid;
      end
   endgenerate
endmodule

// File: tb/tb_minmax_sel.sv
`timescale 1ns/1ps
module tb_minmax_sel;
   localparam int W = 64;
   localparam logic [W-1:0] MINNEG = 64'h8000_0000_0000_0000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [1:0]   mode = 2'd0;
   logic         rec_en = 1'b0;
   logic [W-1:0] result;
   logic [3:0]   cond;
   logic         cond_valid;
   logic         out_valid;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   minmax_sel #(.WIDTH(W), .REGISTERED(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .mode(mode), .rec_en(rec_en), .result(result), .cond(cond),
      .cond_valid(cond_valid), .out_valid(out_valid)
   );

   function automatic logic [W-1:0] exp_res(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m);
      logic a_less, a_more;
      a_less = m[1] ? ($signed(a) < $signed(b)) : (a < b);
      a_more = m[1] ? ($signed(a) > $signed(b)) : (a > b);
      if (m[0]) return a_less ? b : a;
      return a_more ? b : a;
   endfunction

   function automatic logic [3:0] exp_cond(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m, logic r);
      if (!r) return 4'b0000;
      if (a == b) return 4'b0010;
      if (m[1] ? ($signed(a) < $signed(b)) : (a < b)) return 4'b1000;
      return 4'b0100;
   endfunction

   task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive at negedge, capture at the next posedge, sample at the following negedge.
   task automatic run_op(string req, logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m, logic r);
      op_a = a; op_b = b; mode = m; rec_en = r; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "result", result, exp_res(a, b, m));
      chk(req, "cond", {60'd0, cond}, {60'd0, exp_cond(a, b, m, r)});
      chk(req, "cond_valid", {63'd0, cond_valid}, {63'd0, r});
      chk(req, "out_valid", {63'd0, out_valid}, 64'd1);
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] hold_r;
      logic [3:0]   hold_c;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "result", result, '0);
      chk("R10", "cond", {60'd0, cond}, 64'd0);
      chk("R10", "cond_valid", {63'd0, cond_valid}, 64'd0);
      chk("R10", "out_valid", {63'd0, out_valid}, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      // R3 R2 unsigned flavours
      run_op("R3", 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 2'd1, 1'b1);
      run_op("R2", 64'd1, MINNEG, 2'd0, 1'b1);
      run_op("R2", 64'hffff_ffff_ffff_ffff, 64'd2, 2'd0, 1'b1);
      // R5 R4 signed flavours, sign-bit boundary
      run_op("R5", MINNEG, 64'd1, 2'd3, 1'b1);
      run_op("R5", 64'd1, MINNEG, 2'd3, 1'b1);
      run_op("R4", 64'd1, MINNEG, 2'd2, 1'b1);
      run_op("R4", 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 2'd2, 1'b1);
      run_op("R6", 64'hc523e996a8ff6215, 64'd0, 2'd3, 1'b1);
      run_op("R6", 64'd1, 64'd0, 2'd3, 1'b1);
      // R7 ties
      run_op("R7", MINNEG, MINNEG, 2'd3, 1'b1);
      run_op("R7", 64'd5, 64'd5, 2'd0, 1'b1);
      // R8 record off
      run_op("R8", 64'd1, 64'd2, 2'd1, 1'b0);
      run_op("R8", MINNEG, MINNEG, 2'd2, 1'b0);

      // R9 hold between strobes
      run_op("R9", 64'd7, 64'd9, 2'd1, 1'b1);
      hold_r = result; hold_c = cond;
      op_a = 64'h1234; op_b = 64'hffff; mode = 2'd0; rec_en = 1'b0;
      @(negedge clk);
      chk("R9", "hold result", result, hold_r);
      chk("R9", "hold cond", {60'd0, cond}, {60'd0, hold_c});
      chk("R9", "idle out_valid", {63'd0, out_valid}, 64'd0);

      // R1 random sweep over all modes
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] ra, rb;
         logic [1:0] rm;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rm = 2'($urandom);
         case ($urandom % 5)
            0: rb = ra;
            1: rb = ra ^ MINNEG;
            2: ra[W-1] = ~rb[W-1];
            default: ;
         endcase
         run_op("R1", ra, rb, rm, 1'($urandom));
      end

      // R10 reset clears captured values
      run_op("R10", 64'd3, 64'd4, 2'd1, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      chk("R10", "result after reset", result, '0);
      chk("R10", "cond_valid after reset", {63'd0, cond_valid}, 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule